// File: doc/BRIEF.md
# Single-Cycle Processor Core with Post-Increment Load

This block is a single-cycle 32-bit processor core for a small load/store instruction subset. Every clock edge retires one whole instruction. The subset covers register-to-register arithmetic and logic, word loads and stores, and branch-on-equal. It is extended with four further operations: a register-indirect jump, a left shift by an immediate amount, a load of a 16-bit immediate into the upper half of a register, and a load that post-increments its index register.

The post-increment load writes two registers in the same cycle: the loaded word and the index register plus one. For this reason the register file has a second write port, and the main decoder drives an extra enable for that port.

Instruction memory and data memory sit outside the core. Both are read combinationally through plain address and data ports, and data memory is written on the clock edge when the write strobe is high. A debug read port lets the surrounding logic observe any architectural register.

Top module: `scp_core`

## Requirements
- R1: While the synchronous active-high reset is high at a clock edge, the PC becomes 0, every register becomes 0, and the data-memory read and write strobes are held low.
- R2: Opcode 0x00 with funct 0x20, 0x22, 0x24, 0x25 or 0x2A writes the rd register (bits 15:11). The value written is rs+rt, rs-rt, rs AND rt, rs OR rt, or the signed comparison rs<rt as 1 or 0, respectively. The rs field is bits 25:21 and the rt field is bits 20:16.
- R3: Opcode 0x23 loads the word at byte address R[rs]+sign-extended imm[15:0] into rt. Opcode 0x2B stores R[rt] to that address and writes no register.
- R4: Opcode 0x04 sets the PC to PC+4+(sign-extended imm<<2) when R[rs]==R[rt], and to PC+4 otherwise.
- R5: Opcode 0x00 with funct 0x08 loads the PC from R[rs] and writes no register, even when the rd field is nonzero.
- R6: Opcode 0x00 with funct 0x00 writes R[rt] shifted left by the shamt field (bits 10:6) into rd.
- R7: Opcode 0x0F writes {imm[15:0], 16'h0000} into rt.
- R8: Opcode 0x30 loads the word at R[rt]+sign-extended imm into rs. In the same cycle it writes R[rt]+1 into rt.
- R9: When opcode 0x30 names the same register as both rs and rt, that register receives the loaded word.
- R10: Register 0 always reads as zero, and writes aimed at it are discarded.
- R11: Every instruction other than a taken branch or a register jump advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_rdata | input | 32 | Instruction word at imem_addr |
| dmem_addr | output | 32 | Data-memory byte address |
| dmem_wdata | output | 32 | Data to store |
| dmem_rdata | input | 32 | Word read at dmem_addr |
| dmem_we | output | 1 | Store strobe, taken at the clock edge |
| dmem_re | output | 1 | Load strobe |
| dbg_sel | input | 5 | Register number for the debug read port |
| dbg_data | output | 32 | Contents of register dbg_sel |

## Verification
A wrong control word or a wrong write-port selection shows up in the register file one edge after the offending instruction. The bench checks this through the debug port at the following falling edge. A wrong next-PC choice moves imem_addr in that same cycle, so the directed branch and jump programs sample the PC after each control transfer. Errors in write-port priority or in register-0 protection leave a wrong value in a named register, and this value persists until reset, so checks made at the end of each program still catch it.

// File: rtl/scp_pkg.sv
package scp_pkg;

  localparam logic [5:0] OPC_REG   = 6'h00;
  localparam logic [5:0] OPC_BEQ   = 6'h04;
  localparam logic [5:0] OPC_LUI   = 6'h0F;
  localparam logic [5:0] OPC_LW    = 6'h23;
  localparam logic [5:0] OPC_SW    = 6'h2B;
  localparam logic [5:0] OPC_LDINC = 6'h30;

  localparam logic [5:0] FN_SLL = 6'h00;
  localparam logic [5:0] FN_JR  = 6'h08;
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {AOP_ADD = 2'b00, AOP_SUB = 2'b01, AOP_FUNCT = 2'b10} aluop_e;
  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT, ALU_SLL} alu_fn_e;
  typedef enum logic [1:0] {DST_RT, DST_RD, DST_RS} dst_sel_e;
  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_UPPER} wb_sel_e;

  typedef struct packed {
    dst_sel_e dst;
    logic     alu_imm;
    wb_sel_e  wb;
    logic     reg_we;
    logic     mem_rd;
    logic     mem_wr;
    logic     branch;
    aluop_e   alu_op;
    logic     jump_reg;
    logic     idx_we;
  } ctrl_t;

endpackage

// File: rtl/scp_decoder.sv
module scp_decoder
  import scp_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctl
);

  always_comb begin
    ctl          = '0;
    ctl.dst      = DST_RT;
    ctl.wb       = WB_ALU;
    ctl.alu_op   = AOP_ADD;
    unique case (opcode)
      OPC_REG: begin
        if (funct == FN_JR) begin
          ctl.jump_reg = 1'b1;
        end else begin
          ctl.dst    = DST_RD;
          ctl.reg_we = 1'b1;
          ctl.alu_op = AOP_FUNCT;
        end
      end
      OPC_LW: begin
        ctl.alu_imm = 1'b1;
        ctl.wb      = WB_MEM;
        ctl.reg_we  = 1'b1;
        ctl.mem_rd  = 1'b1;
      end
      OPC_SW: begin
        ctl.alu_imm = 1'b1;
        ctl.mem_wr  = 1'b1;
      end
      OPC_BEQ: begin
        ctl.branch = 1'b1;
        ctl.alu_op = AOP_SUB;
      end
      OPC_LUI: begin
        ctl.wb     = WB_UPPER;
        ctl.reg_we = 1'b1;
      end
      OPC_LDINC: begin
        ctl.dst     = DST_RS;
        ctl.alu_imm = 1'b1;
        ctl.wb      = WB_MEM;
        ctl.reg_we  = 1'b1;
        ctl.mem_rd  = 1'b1;
        ctl.idx_we  = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/scp_alu_ctl.sv
module scp_alu_ctl
  import scp_pkg::*;
(
  input  aluop_e     alu_op,
  input  logic [5:0] funct,
  output alu_fn_e    fn
);

  always_comb begin
    fn = ALU_ADD;
    case (alu_op)
      AOP_SUB: fn = ALU_SUB;
      AOP_FUNCT: begin
        case (funct)
          FN_SUB:  fn = ALU_SUB;
          FN_AND:  fn = ALU_AND;
          FN_OR:   fn = ALU_OR;
          FN_SLT:  fn = ALU_SLT;
          FN_SLL:  fn = ALU_SLL;
          default: fn = ALU_ADD;
        endcase
      end
      default: fn = ALU_ADD;
    endcase
  end

endmodule

// File: rtl/scp_alu.sv
module scp_alu
  import scp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SH_W   = 5
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [SH_W-1:0]   shamt,
  input  alu_fn_e           fn,
  output logic [DATA_W-1:0] y,
  output logic              zero
);

  always_comb begin
    case (fn)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(DATA_W-1){1'b0}}, ($signed(a) < $signed(b))};
      ALU_SLL: y = b << shamt;
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);

endmodule

// File: rtl/scp_regfile.sv
module scp_regfile #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ra1,
  input  logic [ADDR_W-1:0] ra2,
  input  logic [ADDR_W-1:0] ra3,
  output logic [DATA_W-1:0] rd1,
  output logic [DATA_W-1:0] rd2,
  output logic [DATA_W-1:0] rd3,
  input  logic              we_a,
  input  logic [ADDR_W-1:0] wa_a,
  input  logic [DATA_W-1:0] wd_a,
  input  logic              we_b,
  input  logic [ADDR_W-1:0] wa_b,
  input  logic [DATA_W-1:0] wd_b
);

  localparam int NREG = 1 << ADDR_W;

  logic [DATA_W-1:0] regs [NREG];

  // Port B is applied first so port A overrides it on a shared address.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      if (we_b && wa_b != '0) regs[wa_b] <= wd_b;
      if (we_a && wa_a != '0) regs[wa_a] <= wd_a;
    end
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
  assign rd3 = (ra3 == '0) ? '0 : regs[ra3];

  a_r10_zero_kept: assert property (@(posedge clk) disable iff (rst)
    regs[0] == '0);

  a_r9_port_a_wins: assert property (@(posedge clk) disable iff (rst)
    (we_a && we_b && wa_a == wa_b && wa_a != '0) |=> regs[$past(wa_a)] == $past(wd_a));

  a_r8_index_written: assert property (@(posedge clk) disable iff (rst)
    (we_b && wa_b != '0 && !(we_a && wa_a == wa_b)) |=> regs[$past(wa_b)] == $past(wd_b));

endmodule

// File: rtl/scp_core.sv
module scp_core
  import scp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_AW = 5
) (
  input  logic              clk,
  input  logic              rst,
  output logic [DATA_W-1:0] imem_addr,
  input  logic [DATA_W-1:0] imem_rdata,
  output logic [DATA_W-1:0] dmem_addr,
  output logic [DATA_W-1:0] dmem_wdata,
  input  logic [DATA_W-1:0] dmem_rdata,
  output logic              dmem_we,
  output logic              dmem_re,
  input  logic [REG_AW-1:0] dbg_sel,
  output logic [DATA_W-1:0] dbg_data
);

  localparam int IMM_W  = 16;
  localparam int STEP   = 4;
  localparam int WORD_SH = 2;

  logic [DATA_W-1:0] pc;
  logic [5:0]        f_op, f_fn;
  logic [REG_AW-1:0] f_rs, f_rt, f_rd, f_sh;
  logic [IMM_W-1:0]  f_imm;
  logic [DATA_W-1:0] imm_sx, pc_inc, br_tgt, pc_nxt;
  logic [DATA_W-1:0] rs_val, rt_val, alu_a, alu_b, alu_y, wb_data;
  logic [REG_AW-1:0] dst_addr;
  logic              alu_zero, br_take;
  ctrl_t             ctl;
  alu_fn_e           alu_fn;

  assign f_op  = imem_rdata[31:26];
  assign f_rs  = imem_rdata[25:21];
  assign f_rt  = imem_rdata[20:16];
  assign f_rd  = imem_rdata[15:11];
  assign f_sh  = imem_rdata[10:6];
  assign f_fn  = imem_rdata[5:0];
  assign f_imm = imem_rdata[15:0];

  assign imm_sx = {{(DATA_W-IMM_W){f_imm[IMM_W-1]}}, f_imm};

  scp_decoder u_dec (
    .opcode (f_op),
    .funct  (f_fn),
    .ctl    (ctl)
  );

  scp_alu_ctl u_aluctl (
    .alu_op (ctl.alu_op),
    .funct  (f_fn),
    .fn     (alu_fn)
  );

  scp_regfile #(.DATA_W(DATA_W), .ADDR_W(REG_AW)) u_rf (
    .clk  (clk),
    .rst  (rst),
    .ra1  (f_rs),
    .ra2  (f_rt),
    .ra3  (dbg_sel),
    .rd1  (rs_val),
    .rd2  (rt_val),
    .rd3  (dbg_data),
    .we_a (ctl.reg_we),
    .wa_a (dst_addr),
    .wd_a (wb_data),
    .we_b (ctl.idx_we),
    .wa_b (f_rt),
    .wd_b (rt_val + 1'b1)
  );

  // The post-increment load addresses from its index register (rt).
  assign alu_a = ctl.idx_we  ? rt_val : rs_val;
  assign alu_b = ctl.alu_imm ? imm_sx : rt_val;

  scp_alu #(.DATA_W(DATA_W), .SH_W(REG_AW)) u_alu (
    .a     (alu_a),
    .b     (alu_b),
    .shamt (f_sh),
    .fn    (alu_fn),
    .y     (alu_y),
    .zero  (alu_zero)
  );

  always_comb begin
    case (ctl.dst)
      DST_RD:  dst_addr = f_rd;
      DST_RS:  dst_addr = f_rs;
      default: dst_addr = f_rt;
    endcase
    case (ctl.wb)
      WB_MEM:   wb_data = dmem_rdata;
      WB_UPPER: wb_data = {f_imm, {(DATA_W-IMM_W){1'b0}}};
      default:  wb_data = alu_y;
    endcase
  end

  assign pc_inc  = pc + STEP;
  assign br_tgt  = pc_inc + (imm_sx << WORD_SH);
  assign br_take = ctl.branch && alu_zero;

  always_comb begin
    if (ctl.jump_reg)  pc_nxt = rs_val;
    else if (br_take)  pc_nxt = br_tgt;
    else               pc_nxt = pc_inc;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_nxt;
  end

  assign imem_addr  = pc;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctl.mem_wr && !rst;
  assign dmem_re    = ctl.mem_rd && !rst;

  a_r11_pc_step: assert property (@(posedge clk) disable iff (rst)
    (!ctl.branch && !ctl.jump_reg) |=> imem_addr == $past(imem_addr) + STEP);

  a_r5_jr_target: assert property (@(posedge clk) disable iff (rst)
    ctl.jump_reg |=> imem_addr == $past(rs_val));

  a_r4_beq_taken: assert property (@(posedge clk) disable iff (rst)
    (ctl.branch && rs_val == rt_val) |=> imem_addr == $past(imem_addr) + STEP + ($past(imm_sx) << WORD_SH));

  a_r3_store_no_regwrite: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> !ctl.reg_we && !ctl.idx_we);

  a_r5_jr_no_regwrite: assert property (@(posedge clk) disable iff (rst)
    ctl.jump_reg |-> !ctl.reg_we && !dmem_we);

  a_r1_reset_pc: assert property (@(posedge clk)
    rst |=> imem_addr == '0);

endmodule

// File: tb/scp_core_tb.sv
module scp_core_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata, dbg_data;
  logic        dmem_we, dmem_re;
  logic [4:0]  dbg_sel = '0;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  scp_core u_dut (
    .clk        (clk),
    .rst        (rst),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .dmem_rdata (dmem_rdata),
    .dmem_we    (dmem_we),
    .dmem_re    (dmem_re),
    .dbg_sel    (dbg_sel),
    .dbg_data   (dbg_data)
  );

  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;

  function automatic logic [31:0] rtype(input int rs, input int rt, input int rd,
                                        input int sh, input int fn);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn[5:0]};
  endfunction

  function automatic logic [31:0] itype(input int op, input int rs, input int rt, input int imm);
    return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_reg(input string tag, input int r, input logic [31:0] exp);
    dbg_sel = r[4:0];
    #1;
    check(tag, dbg_data, exp);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'h0;
      dmem[i] = 32'h0;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_alu_mem();
    clear_mem();
    dmem[0] = 32'd5;
    dmem[1] = 32'd3;
    imem[0]  = itype(8'h23, 0, 2, 0);
    imem[1]  = itype(8'h23, 0, 3, 4);
    imem[2]  = rtype(2, 3, 4, 0, 8'h20);
    imem[3]  = rtype(3, 2, 5, 0, 8'h22);
    imem[4]  = rtype(2, 3, 6, 0, 8'h24);
    imem[5]  = rtype(2, 3, 7, 0, 8'h25);
    imem[6]  = rtype(5, 2, 8, 0, 8'h2A);
    imem[7]  = rtype(0, 2, 9, 4, 8'h00);
    imem[8]  = itype(8'h0F, 0, 1, 16'h1234);
    imem[9]  = rtype(2, 3, 0, 0, 8'h20);
    imem[10] = itype(8'h2B, 0, 4, 8);
    imem[11] = itype(8'h23, 0, 10, 8);
    imem[12] = itype(8'h04, 0, 0, -1);
    do_reset();
    run(16);
    chk_reg("R3 lw r2", 2, 32'd5);
    chk_reg("R2 add", 4, 32'd8);
    chk_reg("R2 sub", 5, 32'hFFFF_FFFE);
    chk_reg("R2 and", 6, 32'd1);
    chk_reg("R2 or", 7, 32'd7);
    chk_reg("R2 slt signed", 8, 32'd1);
    chk_reg("R6 sll", 9, 32'd80);
    chk_reg("R7 lui", 1, 32'h1234_0000);
    chk_reg("R10 r0 write ignored", 0, 32'h0);
    check("R3 sw memory", dmem[2], 32'd8);
    chk_reg("R3 lw after sw", 10, 32'd8);
    check("R11 pc at loop", imem_addr, 32'd48);
  endtask

  task automatic t_flow();
    clear_mem();
    dmem[0] = 32'd5;
    dmem[1] = 32'd5;
    dmem[2] = 32'd64;
    imem[0]  = itype(8'h23, 0, 1, 0);
    imem[1]  = itype(8'h23, 0, 2, 4);
    imem[2]  = itype(8'h23, 0, 3, 8);
    imem[3]  = itype(8'h04, 1, 2, 2);
    imem[4]  = itype(8'h23, 0, 4, 0);
    imem[5]  = itype(8'h23, 0, 4, 0);
    imem[6]  = itype(8'h04, 1, 3, 5);
    imem[7]  = rtype(3, 0, 7, 0, 8'h08);
    imem[8]  = itype(8'h23, 0, 5, 0);
    imem[16] = itype(8'h23, 0, 6, 4);
    imem[17] = itype(8'h04, 0, 0, -1);
    do_reset();
    run(3);
    check("R11 pc after three loads", imem_addr, 32'd12);
    run(1);
    check("R4 beq taken target", imem_addr, 32'd24);
    run(1);
    check("R4 beq not taken", imem_addr, 32'd28);
    run(1);
    check("R5 jr target", imem_addr, 32'd64);
    run(4);
    chk_reg("R4 skipped load r4", 4, 32'h0);
    chk_reg("R5 skipped load r5", 5, 32'h0);
    chk_reg("R5 jr no rd write", 7, 32'h0);
    chk_reg("R5 target executed", 6, 32'd5);
    check("R4 self loop", imem_addr, 32'd68);
  endtask

  task automatic t_ldinc();
    clear_mem();
    dmem[0]  = 32'h20;
    dmem[8]  = 32'hBBBB_0002;
    dmem[9]  = 32'hAAAA_0001;
    dmem[10] = 32'hCCCC_0003;
    imem[0] = itype(8'h23, 0, 1, 0);
    imem[1] = itype(8'h30, 2, 1, 4);
    imem[2] = itype(8'h30, 3, 1, -1);
    imem[3] = itype(8'h23, 0, 4, 0);
    imem[4] = itype(8'h30, 4, 4, 8);
    imem[5] = itype(8'h30, 0, 1, 2);
    imem[6] = itype(8'h04, 0, 0, -1);
    do_reset();
    run(2);
    chk_reg("R8 loaded word", 2, 32'hAAAA_0001);
    chk_reg("R8 index plus one", 1, 32'h21);
    run(6);
    chk_reg("R8 negative offset", 3, 32'hBBBB_0002);
    chk_reg("R9 same reg loaded wins", 4, 32'hCCCC_0003);
    chk_reg("R10 rs zero index still steps", 1, 32'h23);
    chk_reg("R10 r0 stays zero", 0, 32'h0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 pc cleared", imem_addr, 32'h0);
    check("R1 store strobe low", {31'h0, dmem_we}, 32'h0);
    check("R1 load strobe low", {31'h0, dmem_re}, 32'h0);
    chk_reg("R1 register cleared", 1, 32'h0);
    chk_reg("R1 register cleared", 4, 32'h0);
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_mem();
    t_alu_mem();
    t_flow();
    t_ldinc();
    t_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule